// File: doc/BRIEF.md
# Two-Button Tone Code Selector

This block holds a 4-bit tone code, a value from 0 to 15, that a user steps up and down with two push buttons. The code is shown on two 2-bit selects, a row select and a column select. A tone generator further down the chain uses them to pick one low and one high frequency. The left button steps the code up by one and the right button steps it down by one. Both steps wrap around modulo 16. A small state machine makes sure that holding a button gives exactly one step. The button that caused a step has to be seen released before any further step can happen.

The two raw button levels first pass through a two-stage flip-flop synchroniser. The state machine does not advance on every clock. It advances only in cycles where `sample_en` is high, and `sample_en` is a one-cycle pulse at the audio sample rate. This sampling at the audio rate is also the only filtering applied to button bounce. The machine has three states:

- `ST_WAIT`: no step is in progress.
- `ST_UP_HELD`: the left button caused an up-step and the machine waits for that button to be released.
- `ST_DN_HELD`: the right button caused a down-step and the machine waits for that button to be released.

Its transitions, all taken only on a `sample_en` cycle, are:

- WAIT→UP_HELD: left button down; the code steps up.
- WAIT→DN_HELD: right button down and left button up; the code steps down.
- UP_HELD→WAIT: left button up.
- DN_HELD→WAIT: right button up.
- Any unused state encoding goes back to WAIT.

Top module: `tone_code_selector`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the code to 0, so `row_sel` and `col_sel` read 0. It also puts the machine in ST_WAIT.
- R2: In ST_WAIT, on a `sample_en` cycle with the synchronised left button high, the code becomes (code+1) mod 16, so 15 steps to 0. The machine then moves to ST_UP_HELD.
- R3: In ST_WAIT, on a `sample_en` cycle with the synchronised right button high and the left button low, the code becomes (code+15) mod 16, so 0 steps to 15. The machine then moves to ST_DN_HELD.
- R4: When both synchronised buttons are high in ST_WAIT on a `sample_en` cycle, only the up-step is taken.
- R5: In ST_UP_HELD or ST_DN_HELD the code does not change. The machine returns to ST_WAIT only on a `sample_en` cycle where the button that caused the step reads low. Holding a button therefore gives one step only.
- R6: In ST_UP_HELD the right button has no effect, and in ST_DN_HELD the left button has no effect.
- R7: In a cycle with `sample_en` low, neither the code nor the state changes, whatever the buttons do.
- R8: A button level is used by the machine two clock edges after it is captured. A level first captured at edge k can first cause a step on a `sample_en` cycle at edge k+2.
- R9: `row_sel` equals code bits [3:2] (code / 4) and `col_sel` equals code bits [1:0] (code mod 4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | One-cycle pulse at the audio sample rate; the machine advances only when it is high |
| btn_left | input | 1 | Raw left button level, high while pressed (step up) |
| btn_right | input | 1 | Raw right button level, high while pressed (step down) |
| row_sel | output | 2 | Code / 4 |
| col_sel | output | 2 | Code mod 4 |

## Verification
A button change driven before edge k takes two edges to pass the synchroniser. It can therefore first change the code at the `sample_en` edge k+2. The new code shows on `row_sel`/`col_sel` straight after that edge, because the selects are plain wiring from the code register.

The bench drives all inputs on falling edges. Its reference model keeps a two-entry history of the sampled button levels, and it steps its code and state on the same rising edges as the design. Outputs are compared on every falling edge, so each result is checked in exactly the cycle it is due. The directed checks include one that fires `sample_en` one edge too early and expects no step, then fires it at k+2 and expects the step.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    // Width of the tone code; row and column share it equally.
    localparam int CODE_W = 4;

    // Hold-state machine encoding.
    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_UP_HELD = 2'd1,
        ST_DN_HELD = 2'd2
    } step_state_e;

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], raw_i[b]};
            end
        end

        assign sync_o[b] = chain_q[LAST];
    end

    // R8: a captured level reaches the machine two edges later.
    p_sync_delay_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_o == $past(raw_i, 2)));

endmodule

// File: rtl/step_fsm.sv
module step_fsm
    import tsel_pkg::*;
#(
    parameter int W = CODE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         smp_i,
    input  logic         up_i,
    input  logic         dn_i,
    output logic [W-1:0] code_o
);

    localparam logic [W-1:0] ONE = W'(1);

    step_state_e  st_q, st_d;
    logic [W-1:0] code_q, code_d;

    // State and code register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_WAIT;
            code_q <= '0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
        end
    end

    // Transitions, taken only on a sample cycle.
    always_comb begin
        st_d   = st_q;
        code_d = code_q;
        if (smp_i) begin
            unique case (st_q)
                ST_WAIT: begin
                    if (up_i) begin
                        st_d   = ST_UP_HELD;
                        code_d = code_q + ONE;
                    end else if (dn_i) begin
                        st_d   = ST_DN_HELD;
                        code_d = code_q - ONE;
                    end
                end
                ST_UP_HELD: begin
                    if (!up_i) st_d = ST_WAIT;
                end
                ST_DN_HELD: begin
                    if (!dn_i) st_d = ST_WAIT;
                end
                default: st_d = ST_WAIT;
            endcase
        end
    end

    assign code_o = code_q;

    p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && smp_i && up_i) |=> (code_q == W'($past(code_q) + ONE)));

    p_step_dn_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && smp_i && !up_i && dn_i) |=> (code_q == W'($past(code_q) - ONE)));

    p_left_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WAIT && smp_i && up_i && dn_i) |=> (st_q == ST_UP_HELD));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q != ST_WAIT) |=> $stable(code_q));

    p_up_held_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_UP_HELD && up_i) |=> (st_q == ST_UP_HELD));

    p_dn_held_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DN_HELD && dn_i) |=> (st_q == ST_DN_HELD));

    p_idle_sample_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_i |=> ($stable(code_q) && $stable(st_q)));

    p_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (code_q == '0 && st_q == ST_WAIT));

endmodule

// File: rtl/code_split.sv
module code_split #(
    parameter int W     = 4,
    parameter int COL_W = 2
) (
    input  logic [W-1:0]       code_i,
    output logic [W-COL_W-1:0] row_o,
    output logic [COL_W-1:0]   col_o
);

    assign row_o = code_i[W-1:COL_W];
    assign col_o = code_i[COL_W-1:0];

endmodule

// File: rtl/tone_code_selector.sv
module tone_code_selector
    import tsel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_en,
    input  logic       btn_left,
    input  logic       btn_right,
    output logic [1:0] row_sel,
    output logic [1:0] col_sel
);

    localparam int COL_W = CODE_W / 2;

    logic [1:0]        btn_s;
    logic [CODE_W-1:0] code;

    btn_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  ({btn_right, btn_left}),
        .sync_o (btn_s)
    );

    step_fsm #(.W(CODE_W)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .smp_i  (sample_en),
        .up_i   (btn_s[0]),
        .dn_i   (btn_s[1]),
        .code_o (code)
    );

    code_split #(.W(CODE_W), .COL_W(COL_W)) u_split (
        .code_i (code),
        .row_o  (row_sel),
        .col_o  (col_sel)
    );

endmodule

// File: tb/tone_code_selector_tb.sv
module tone_code_selector_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_en = 1'b0;
    logic       btn_left = 1'b0;
    logic       btn_right = 1'b0;
    logic [1:0] row_sel, col_sel;

    int total = 0;
    int bad = 0;
    bit smp_run = 1'b0;
    bit smp_force = 1'b0;
    int smp_cnt = 0;

    // Reference model: integers and queues only.
    int mcode = 0;
    int mst = 0;                 // 0 wait, 1 up held, 2 down held
    int lq[$];
    int rq[$];

    always #10 clk = ~clk;       // 50 MHz

    tone_code_selector u_dut (
        .clk(clk), .rst(rst), .sample_en(sample_en),
        .btn_left(btn_left), .btn_right(btn_right),
        .row_sel(row_sel), .col_sel(col_sel)
    );

    // sample_en generator, driven away from the rising edge.
    always @(negedge clk) begin
        smp_cnt <= smp_cnt + 1;
        sample_en <= smp_run ? (smp_cnt % 4 == 3) : smp_force;
    end

    always @(posedge clk) begin
        int l, r;
        if (rst) begin
            mcode = 0; mst = 0;
            lq.delete(); rq.delete();
            lq.push_back(0); lq.push_back(0);
            rq.push_back(0); rq.push_back(0);
        end else begin
            l = lq[0]; r = rq[0];
            if (sample_en) begin
                if (mst == 0) begin
                    if (l != 0)      begin mcode = (mcode + 1) % 16;  mst = 1; end
                    else if (r != 0) begin mcode = (mcode + 15) % 16; mst = 2; end
                end else if (mst == 1) begin
                    if (l == 0) mst = 0;
                end else begin
                    if (r == 0) mst = 0;
                end
            end
            void'(lq.pop_front()); lq.push_back(int'(btn_left));
            void'(rq.pop_front()); rq.push_back(int'(btn_right));
        end
    end

    // Per-cycle comparison against the model (R9 split of the model code).
    always @(negedge clk) begin
        if (!rst) begin
            total++;
            if (row_sel != 2'(mcode / 4) || col_sel != 2'(mcode % 4)) begin
                bad++;
                $display("FAIL R9 model row=%0d col=%0d expected row=%0d col=%0d",
                         row_sel, col_sel, mcode / 4, mcode % 4);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_code(input int exp, input string req);
        total++;
        if (row_sel != 2'(exp / 4) || col_sel != 2'(exp % 4)) begin
            bad++;
            $display("FAIL %s code=%0d expected=%0d", req,
                     {row_sel, col_sel}, exp);
        end
    endtask

    initial begin
        tick(3);
        check_code(0, "R1 reset");
        rst = 1'b0;
        smp_run = 1'b1;

        // R2 / R5: one step per hold
        btn_left = 1'b1;  tick(24); check_code(1, "R2 single up-step R5");
        btn_left = 1'b0;  tick(12); check_code(1, "R5 release no step");
        btn_left = 1'b1;  tick(12); btn_left = 1'b0; tick(12);
        btn_left = 1'b1;  tick(12); btn_left = 1'b0; tick(12);
        check_code(3, "R2 repeated presses");

        // R3 and wrap
        repeat (3) begin btn_right = 1'b1; tick(12); btn_right = 1'b0; tick(12); end
        check_code(0, "R3 down to 0");
        btn_right = 1'b1; tick(20); check_code(15, "R3 wrap 0 to 15");
        btn_right = 1'b0; tick(12);
        btn_left = 1'b1;  tick(12); btn_left = 1'b0; tick(12);
        check_code(0, "R2 wrap 15 to 0");

        // R4 both pressed
        btn_left = 1'b1; btn_right = 1'b1; tick(20);
        check_code(1, "R4 left priority");
        btn_left = 1'b0; btn_right = 1'b0; tick(12);

        // R6 right ignored while up held
        btn_left = 1'b1; tick(12); check_code(2, "R2 up for R6");
        btn_right = 1'b1; tick(16); check_code(2, "R6 right ignored in up-held");
        btn_right = 1'b0; tick(8); btn_left = 1'b0; tick(12);
        // R6 left ignored while down held
        btn_right = 1'b1; tick(12); check_code(1, "R3 down for R6");
        btn_left = 1'b1; tick(16); check_code(1, "R6 left ignored in down-held");
        btn_left = 1'b0; tick(8); btn_right = 1'b0; tick(12);

        // R7 no sample_en
        smp_run = 1'b0; tick(2);
        btn_left = 1'b1; tick(20); check_code(1, "R7 no step without sample_en");
        btn_left = 1'b0; tick(6);

        // R8 synchroniser latency
        btn_left = 1'b1; smp_force = 1'b1; tick(1);
        smp_force = 1'b0; tick(1); check_code(1, "R8 too early no step");
        smp_force = 1'b1; tick(1);
        smp_force = 1'b0; tick(1); check_code(2, "R8 step at k+2");
        btn_left = 1'b0; tick(4);
        smp_force = 1'b1; tick(1); smp_force = 1'b0; tick(2);

        // R9 split for a mixed code: step to 6
        smp_run = 1'b1;
        repeat (4) begin btn_left = 1'b1; tick(12); btn_left = 1'b0; tick(12); end
        check_code(6, "R9 row=1 col=2");

        // R1 reset mid-run
        rst = 1'b1; tick(2); check_code(0, "R1 reset mid-run");
        rst = 1'b0; tick(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule